// File: doc/BRIEF.md
# I2C Bus Master with Command-Pulse Control

This block is a master for a two-wire serial bus (I2C). It generates the bus clock by dividing the system clock, and it drives an open-drain data line. Software-side logic starts a transfer with a start pulse. The transfer takes its target from configuration inputs: a 7-bit device address, a direction bit and an internal-address length of zero to three bytes. A stop pulse ends the transfer. The number of bytes is never programmed. A write ends when the transmit holding register is empty and a stop has been requested. A read ends on the byte during which the stop request is seen.

Data moves through two one-entry holding registers that use valid/ready handshakes. On the transmit side, `tx_ready` is high exactly when the holding register is empty. A byte transfers on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the source must keep `tx_valid` and `tx_data` steady. On the receive side, `rx_valid` stays high and `rx_data` stays steady until a cycle where `rx_ready` is high. The bus is the point of back-pressure. When the master has no byte to send, or has nowhere to put a received byte, it holds SCL low and waits.

The bus pins are open-drain style. A 1 on `scl_o` or `sda_o` releases the line, and a 0 pulls it low. `sda_i` is the resolved level of the data line.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `txcomp`=1, `tx_ready`=1, `rx_valid`=0, `nack`=0, and `scl_o`=`sda_o`=1.
- R2: A write sends START, then the byte {device address, 0} MSB first, then each byte taken from the transmit holding register, in the order the bytes were accepted. Each byte is followed by an acknowledge bit that the slave drives.
- R3: A byte accepted on `tx_valid`/`tx_ready` drops `tx_ready` until the master loads that byte for sending. If the holding register is empty and no stop is pending, the master holds SCL low. If a byte is waiting and a stop is pending, the byte is sent before STOP.
- R4: If the slave does not acknowledge a byte the master sent (SDA high when sampled on the ninth clock), the master sets `nack` and issues STOP, with no stop command needed. A later start pulse clears `nack`.
- R5: A read sends {device address, 1}, then receives bytes MSB first into the receive holding register. `rx_valid` stays high with the byte steady until the cycle where `rx_ready` is high.
- R6: The master drives an acknowledge (SDA low) after each received byte, unless a stop is pending when that byte's eighth bit completes. In that case it leaves SDA high (not-acknowledge) and then issues STOP. A start and a stop pulsed in the same cycle give a single-byte read.
- R7: When `iadr_len` is nonzero, that many low bytes of `iadr` are sent after the device address, most significant first. For a read, the master then issues a repeated START and resends the device address with the read bit.
- R8: When a byte's eighth bit is received while `rx_valid` is still high, SCL is held low until the holding register is emptied.
- R9: `txcomp` falls on the cycle after an accepted start and returns high only once the STOP condition is complete.
- R10: Each SCL high phase and each low phase of a data bit lasts 2×`clk_div` system cycles. SDA changes only while SCL is low, except for the START and STOP edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | System cycles per quarter bit (0 is treated as 1) |
| cmd_start | input | 1 | Start pulse; accepted only when idle |
| cmd_stop | input | 1 | Stop request pulse |
| dev_addr | input | 7 | Target device address |
| rd_mode | input | 1 | 1 = read transfer, 0 = write |
| iadr_len | input | 2 | Internal address bytes to send (0..3) |
| iadr | input | 8*IA_BYTES | Internal address value |
| tx_data | input | 8 | Byte offered for sending |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| txcomp | output | 1 | High while the bus is idle |
| nack | output | 1 | Slave failed to acknowledge |
| scl_o | output | 1 | Clock line: 0 pulls low, 1 releases |
| sda_o | output | 1 | Data line: 0 pulls low, 1 releases |
| sda_i | input | 1 | Resolved data line level |

## Verification
A slip in the bit counter or the shift register shows up within one byte time. The slave model then logs a byte rotated or shifted by one place, or it sees an acknowledge in the wrong slot. A wrong phase decision after the ninth bit is also caught within one byte. Examples are a missing repeated START or an acknowledge where a not-acknowledge belongs. It shows as a wrong read/write bit in the address log, or as a wrong entry in the master-acknowledge log. A wait state that never exits leaves `txcomp` low and SCL stuck low, so the bench sees it on the first port check that follows. An error in the divider changes the measured SCL high time by whole cycles.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BYTE,
    S_TXW,
    S_RXW,
    S_STOP
  } st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IADR,
    K_WR,
    K_RD
  } kind_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R10: with a divider above one, quarter ticks never come back to back
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/i2cm_hold.sv
module i2cm_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (full_q && out_ready) begin
      full_q <= 1'b0;
    end
  end

  // R5: an entry that is not taken keeps its value
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter  int IA_BYTES = 3,
  localparam int IA_W     = 8 * IA_BYTES,
  localparam int IAC_W    = $clog2(IA_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             run,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [6:0]       dev_addr,
  input  logic             rd_mode,
  input  logic [IAC_W-1:0] iadr_len,
  input  logic [IA_W-1:0]  iadr,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  input  logic             rx_room,
  output logic             txcomp,
  output logic             nack,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  st_e              st;
  kind_e            kind;
  logic [1:0]       q;
  logic [3:0]       bcnt;
  logic [7:0]       sh;
  logic [IA_W-1:0]  ia_sh;
  logic [IAC_W-1:0] ia_left;
  logic [6:0]       dev_q;
  logic             rd_q, rd_cur, rep, stop_pend, nack_q, ack_in, ack_out;

  assign run     = (st == S_START) || (st == S_BYTE) || (st == S_STOP);
  assign tx_take = (st == S_TXW) && tx_valid;
  assign rx_push = (st == S_RXW) && rx_room;
  assign rx_byte = sh;
  assign txcomp  = (st == S_IDLE);
  assign nack    = nack_q;

  // quarter map of a bit: q0 low, q1 high, q2 high, q3 low
  always_comb begin
    scl_o = 1'b1;
    sda_o = 1'b1;
    unique case (st)
      S_IDLE: begin
        scl_o = 1'b1;
        sda_o = 1'b1;
      end
      S_START: begin
        scl_o = (q == 2'd0) ? !rep : (q != 2'd3);
        sda_o = (q < 2'd2);
      end
      S_BYTE: begin
        scl_o = (q == 2'd1) || (q == 2'd2);
        if (bcnt != 4'd8) sda_o = (kind == K_RD) ? 1'b1 : sh[7];
        else              sda_o = (kind == K_RD) ? ack_out : 1'b1;
      end
      S_TXW, S_RXW: begin
        scl_o = 1'b0;
        sda_o = 1'b1;
      end
      S_STOP: begin
        scl_o = (q != 2'd0);
        sda_o = (q >= 2'd2);
      end
      default: begin
        scl_o = 1'b1;
        sda_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;      kind <= K_ADDR;    q <= '0;
      bcnt <= '0;        sh <= '0;          ia_sh <= '0;
      ia_left <= '0;     dev_q <= '0;       rd_q <= 1'b0;
      rd_cur <= 1'b0;    rep <= 1'b0;       stop_pend <= 1'b0;
      nack_q <= 1'b0;    ack_in <= 1'b1;    ack_out <= 1'b1;
    end else begin
      if (cmd_stop && st != S_IDLE) stop_pend <= 1'b1;
      unique case (st)
        S_IDLE: if (cmd_start) begin
          st        <= S_START;
          q         <= '0;
          rep       <= 1'b0;
          nack_q    <= 1'b0;
          stop_pend <= cmd_stop;
          dev_q     <= dev_addr;
          rd_q      <= rd_mode;
          rd_cur    <= rd_mode && (iadr_len == '0);
          ia_left   <= iadr_len;
          ia_sh     <= iadr << (8 * (IA_BYTES - int'(iadr_len)));
        end
        S_START: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            st   <= S_BYTE;
            kind <= K_ADDR;
            bcnt <= '0;
            sh   <= {dev_q, rd_cur};
          end
        end
        S_BYTE: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd2) begin
            if (bcnt != 4'd8 && kind == K_RD) sh <= {sh[6:0], sda_i};
            if (bcnt == 4'd8 && kind != K_RD) ack_in <= sda_i;
          end
          if (q == 2'd3) begin
            if (bcnt != 4'd8) begin
              bcnt <= bcnt + 4'd1;
              if (kind != K_RD)       sh <= {sh[6:0], 1'b0};
              else if (bcnt == 4'd7)  st <= S_RXW;
            end else begin
              bcnt <= '0;
              if (kind == K_RD) begin
                if (ack_out) st <= S_STOP;
              end else if (ack_in) begin
                nack_q <= 1'b1;
                st     <= S_STOP;
              end else if (kind == K_ADDR && rd_cur) begin
                kind <= K_RD;
              end else if (ia_left != '0) begin
                kind    <= K_IADR;
                sh      <= ia_sh[IA_W-1 -: 8];
                ia_sh   <= ia_sh << 8;
                ia_left <= ia_left - 1'b1;
              end else if (rd_q) begin
                st     <= S_START;
                rep    <= 1'b1;
                rd_cur <= 1'b1;
              end else begin
                st <= S_TXW;
              end
            end
          end
        end
        S_RXW: if (rx_room) begin
          st      <= S_BYTE;
          q       <= '0;
          ack_out <= stop_pend;
        end
        S_TXW: begin
          if (tx_valid) begin
            st   <= S_BYTE;
            kind <= K_WR;
            sh   <= tx_data;
            bcnt <= '0;
            q    <= '0;
          end else if (stop_pend) begin
            st <= S_STOP;
            q  <= '0;
          end
        end
        S_STOP: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            st        <= S_IDLE;
            stop_pend <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: data line holds while the clock stays high inside a byte
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && scl_o && $past(scl_o) && $past(st) == S_BYTE) |-> $stable(sda_o));
  // R8: a full receive holding register keeps SCL low
  p_rxw_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RXW && !rx_room) |=> !scl_o);
  // R4: a missing acknowledge leads straight into STOP
  p_nack_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_q) |-> (st == S_STOP));
  // R9: an accepted start makes the block busy on the next cycle
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txcomp && cmd_start) |=> !txcomp);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter  int DIV_W    = 16,
  parameter  int IA_BYTES = 3,
  localparam int IA_W     = 8 * IA_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [6:0]       dev_addr,
  input  logic             rd_mode,
  input  logic [1:0]       iadr_len,
  input  logic [IA_W-1:0]  iadr,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             txcomp,
  output logic             nack,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  logic       tick, run;
  logic       txh_valid, tx_take;
  logic [7:0] txh_data;
  logic       rx_push, rx_room;
  logic [7:0] rx_byte;

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
  );

  i2cm_hold #(.W(8)) u_txh (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(txh_valid), .out_ready(tx_take), .out_data(txh_data)
  );

  i2cm_hold #(.W(8)) u_rxh (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_room), .in_data(rx_byte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  i2cm_ctrl #(.IA_BYTES(IA_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .dev_addr(dev_addr), .rd_mode(rd_mode), .iadr_len(iadr_len), .iadr(iadr),
    .tx_valid(txh_valid), .tx_data(txh_data), .tx_take(tx_take),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room),
    .txcomp(txcomp), .nack(nack),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam logic [6:0] SLV = 7'h50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] clk_div = 16'd4;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0;
  logic [6:0]  dev_addr = SLV;
  logic        rd_mode = 1'b0;
  logic [1:0]  iadr_len = 2'd0;
  logic [23:0] iadr = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        txcomp, nack, scl_o, sda_o;
  logic        slave_sda = 1'b1;
  logic        scl_bus, sda_bus;

  assign scl_bus = scl_o;
  assign sda_bus = sda_o & slave_sda;

  always #10 clk = ~clk;

  i2c_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .dev_addr(dev_addr), .rd_mode(rd_mode), .iadr_len(iadr_len), .iadr(iadr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .txcomp(txcomp), .nack(nack), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] addr_log [16];
  logic [7:0] wlog [16];
  logic       mack [16];
  int n_addr = 0, n_w = 0, n_mack = 0;
  logic [7:0] ptr = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  task automatic slv_rx(output logic [7:0] b, output int ev);
    ev = 0;
    b  = '0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_bus);
      b = {b[6:0], sda_bus};
      @(scl_bus or sda_bus);
      if (scl_bus) begin
        ev = sda_bus ? 2 : 1;
        return;
      end
    end
  endtask

  initial begin : slave
    logic [7:0] b, d;
    int ev;
    bit restart;
    bit first;
    logic a;
    restart = 1'b0;
    forever begin
      if (!restart) begin
        do @(negedge sda_bus); while (!scl_bus);
      end
      restart = 1'b0;
      slv_rx(b, ev);
      if (ev == 1) begin restart = 1'b1; continue; end
      if (ev == 2) continue;
      if (n_addr < 16) addr_log[n_addr] = b;
      n_addr++;
      if (b[7:1] != SLV) continue;
      #1 slave_sda = 1'b0;
      @(negedge scl_bus);
      #1 slave_sda = 1'b1;
      if (!b[0]) begin
        first = 1'b1;
        forever begin
          slv_rx(b, ev);
          if (ev == 1) begin restart = 1'b1; break; end
          if (ev == 2) break;
          if (n_w < 16) wlog[n_w] = b;
          n_w++;
          if (first) ptr = b;
          first = 1'b0;
          #1 slave_sda = 1'b0;
          @(negedge scl_bus);
          #1 slave_sda = 1'b1;
        end
      end else begin
        forever begin
          d = ptr ^ 8'h5A;
          ptr = ptr + 8'd1;
          for (int i = 7; i >= 0; i--) begin
            slave_sda = d[i];
            @(negedge scl_bus);
            #1;
          end
          slave_sda = 1'b1;
          @(posedge scl_bus);
          a = sda_bus;
          if (n_mack < 16) mack[n_mack] = a;
          n_mack++;
          @(negedge scl_bus);
          #1;
          if (a) break;
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic cmd(input logic s, input logic p);
    @(negedge clk);
    cmd_start = s;
    cmd_stop  = p;
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_stop  = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    b = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!txcomp) @(negedge clk);
  endtask

  task automatic clear_logs();
    n_addr = 0;
    n_w    = 0;
    n_mack = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 txcomp", txcomp, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 nack", nack, 0);
    chk("R1 scl_o", scl_o, 1);
    chk("R1 sda_o", sda_o, 1);
  endtask

  task automatic t_write();
    int n;
    clear_logs();
    dev_addr = SLV; rd_mode = 1'b0; iadr_len = 2'd0;
    push_tx(8'h3C);
    chk("R3 tx_ready low when held", tx_ready, 0);
    cmd(1'b1, 1'b0);
    chk("R9 txcomp low after start", txcomp, 0);
    @(posedge scl_o);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (scl_o);
    chk("R10 scl high cycles", n, 8);
    push_tx(8'hC3);
    push_tx(8'h81);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (400) @(negedge clk);
    chk("R3 waits with scl low", scl_o, 0);
    chk("R9 busy while waiting", txcomp, 0);
    cmd(1'b0, 1'b1);
    wait_idle();
    chk("R2 address byte", addr_log[0], 8'hA0);
    chk("R2 byte count", n_w, 3);
    chk("R2 data 0", wlog[0], 8'h3C);
    chk("R2 data 1", wlog[1], 8'hC3);
    chk("R2 data 2", wlog[2], 8'h81);
    chk("R4 no nack on good write", nack, 0);
  endtask

  task automatic t_addr_nack();
    clear_logs();
    dev_addr = 7'h22; rd_mode = 1'b0; iadr_len = 2'd0;
    cmd(1'b1, 1'b0);
    wait_idle();
    chk("R4 nack flag set", nack, 1);
    chk("R4 no data sent", n_w, 0);
    chk("R4 bus released", {scl_o, sda_o}, 2'b11);
  endtask

  task automatic t_read_single_iadr();
    logic [7:0] b;
    clear_logs();
    dev_addr = SLV; rd_mode = 1'b1; iadr_len = 2'd1; iadr = 24'h000010;
    cmd(1'b1, 1'b1);
    chk("R4 nack cleared by start", nack, 0);
    wait_idle();
    chk("R7 address count", n_addr, 2);
    chk("R7 first address write", addr_log[0], 8'hA0);
    chk("R7 repeated address read", addr_log[1], 8'hA1);
    chk("R7 internal address byte", wlog[0], 8'h10);
    chk("R6 single byte nacked", {n_mack[3:0], mack[0]}, {4'd1, 1'b1});
    chk("R5 rx_valid held", rx_valid, 1);
    pop_rx(b);
    chk("R5 read data", b, 8'h10 ^ 8'h5A);
    chk("R5 rx_valid cleared", rx_valid, 0);
  endtask

  task automatic t_read_multi();
    logic [7:0] b;
    clear_logs();
    dev_addr = SLV; rd_mode = 1'b1; iadr_len = 2'd0;
    cmd(1'b1, 1'b0);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    repeat (400) @(negedge clk);
    chk("R8 scl held low when full", scl_o, 0);
    chk("R8 first byte kept", rx_data, 8'h11 ^ 8'h5A);
    pop_rx(b);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    cmd(1'b0, 1'b1);
    pop_rx(b);
    chk("R5 second byte", b, 8'h12 ^ 8'h5A);
    wait_idle();
    pop_rx(b);
    chk("R5 third byte", b, 8'h13 ^ 8'h5A);
    chk("R5 read address", addr_log[0], 8'hA1);
    chk("R6 ack count", n_mack, 3);
    chk("R6 ack pattern", {mack[0], mack[1], mack[2]}, 3'b001);
  endtask

  task automatic t_write_iadr2();
    clear_logs();
    dev_addr = SLV; rd_mode = 1'b0; iadr_len = 2'd2; iadr = 24'hFF0123;
    push_tx(8'h99);
    cmd(1'b1, 1'b1);
    wait_idle();
    chk("R7 write byte count", n_w, 3);
    chk("R7 iadr high byte first", wlog[0], 8'h01);
    chk("R7 iadr low byte", wlog[1], 8'h23);
    chk("R3 data before stop", wlog[2], 8'h99);
    chk("R3 holding emptied", tx_ready, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_addr_nack();
    t_read_single_iadr();
    t_read_multi();
    t_write_iadr2();
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule